// File: doc/BRIEF.md
# Boot Script Command Sequencer

After reset this block walks an encoded initialisation script held in a small external boot memory. It pulls the script one 32-bit word at a time over a request/acknowledge fetch port, interprets the words as commands, and turns them into writes on a single-master write bus that has a ready handshake. With these commands a script can program configuration registers, copy a block of code or data into memory, and wait for plls or memories to settle before it continues.

There are four commands. Each starts with a header word whose two most significant bits give the opcode. The remaining header bits carry no meaning. The block stops when the script issues its end command, and it also stops when the fetch pointer runs off the end of the boot image. In both cases a done flag rises. When the image is exhausted an error flag rises as well.

Top module: `boot_script_seq`

## Requirements
- R1: The opcode is bits 31:30 of a header word: 00 is a single write, 01 a block write, 10 an idle and 11 the end of the script. Header bits 29:0 are ignored.
- R2: A single write is the header, then an address word, then a data word. It produces exactly one bus write of that data to that address.
- R3: A block write is the header, then a start address, then a count n, then n data words. Data word k goes to start + 4·k, in script order. When n is 0 there are no writes and the next header follows. Counts of several hundred words (for example 627) work.
- R4: An idle is the header followed by a count t. After the count word is accepted, fetch_req_o stays low for exactly t cycles and bus_valid_o stays low throughout. When t is 0 the next fetch begins at once.
- R5: After an end header is accepted, done_o goes high and stays high, error_o stays low and fetch_req_o is never raised again.
- R6: bus_valid_o, bus_addr_o and bus_data_o hold steady until bus_ready_i is seen high. No fetch is requested while a write is pending.
- R7: Fetch indexes start at 0 and rise by one per accepted word. fetch_req_o and fetch_idx_o hold until fetch_ack_i, and fetch_word_i is taken in the acknowledge cycle. No index above 1023 is ever requested.
- R8: If word 1023 is consumed without an end header, including in the middle of a block write, the block raises done_o and error_o and makes no further fetch.
- R9: While reset is asserted, fetch_idx_o is 0 and done_o, error_o and bus_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req_o | output | 1 | Requests the script word at fetch_idx_o |
| fetch_idx_o | output | 10 | Word index into the boot image |
| fetch_ack_i | input | 1 | Boot memory response; fetch_word_i is valid while it is high |
| fetch_word_i | input | 32 | Returned script word |
| bus_valid_o | output | 1 | Write request on the bus |
| bus_addr_o | output | 32 | Byte address of the write |
| bus_data_o | output | 32 | Data of the write |
| bus_ready_i | input | 1 | Slave accepts the write in this cycle |
| done_o | output | 1 | Script has finished (end header or image exhausted) |
| error_o | output | 1 | Image exhausted without an end header |

## Verification
The first script mixes every command. Its headers carry junk in the unused bits, it includes a zero-length block and a zero-length idle, and a nonzero idle sits between the writes. A scoreboard therefore tells apart the opcode decode, the address stepping and the handling of zero arguments, and the measured gap after each idle count shows whether the wait is off by one. A second script copies 627 words under slow memory and slow bus responses, which exposes any write that moves on early or any dropped or repeated word. Two exhaustion patterns follow: a stream made only of idles, and a block write whose count runs past the image. They separate a normal stop from the error stop and confirm that index 1023 is the last one fetched.

// File: rtl/bss_pkg.sv
package bss_pkg;

    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_WR   = 2'b00,
        OP_LIST = 2'b01,
        OP_IDLE = 2'b10,
        OP_END  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_ADDR,
        ST_ARG,
        ST_DATA,
        ST_BUS,
        ST_IDLE,
        ST_DONE
    } st_e;

endpackage

// File: rtl/bss_fetch.sv
module bss_fetch #(
    parameter int DEPTH = 1024,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             want_i,
    input  logic             fetch_ack_i,
    output logic             fetch_req_o,
    output logic [IDX_W-1:0] fetch_idx_o,
    output logic             take_o,
    output logic             empty_o
);

    localparam int PTR_W = IDX_W + 1;

    logic [PTR_W-1:0] ptr_d, ptr_q;

    assign empty_o     = (ptr_q == PTR_W'(DEPTH));
    assign fetch_req_o = want_i && !empty_o;
    assign fetch_idx_o = ptr_q[IDX_W-1:0];
    assign take_o      = fetch_req_o && fetch_ack_i;

    always_comb begin
        ptr_d = ptr_q;
        if (take_o) begin
            ptr_d = ptr_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o && !fetch_ack_i |=> fetch_req_o && $stable(fetch_idx_o));

    // R7
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_W'(DEPTH));

endmodule

// File: rtl/bss_idle_timer.sv
module bss_idle_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o,
    output logic             busy_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign busy_o = (cnt_q != '0);
    assign last_o = (cnt_q == CNT_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len_i;
        end else if (busy_o) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R4
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o);

endmodule

// File: rtl/bss_wport.sv
module bss_wport #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              bus_ready_i,
    output logic              bus_valid_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              wr_done_o
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wp_t;

    wp_t w_d, w_q;

    assign bus_valid_o = w_q.valid;
    assign bus_addr_o  = w_q.addr;
    assign bus_data_o  = w_q.data;
    assign wr_done_o   = w_q.valid && bus_ready_i;

    always_comb begin
        w_d = w_q;
        if (launch_i) begin
            w_d.valid = 1'b1;
            w_d.addr  = addr_i;
            w_d.data  = data_i;
        end else if (wr_done_o) begin
            w_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    // R6
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o) && $stable(bus_data_o));

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> !bus_valid_o);

endmodule

// File: rtl/boot_script_seq.sv
module boot_script_seq
    import bss_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              fetch_req_o,
    output logic [IDX_W-1:0]  fetch_idx_o,
    input  logic              fetch_ack_i,
    input  logic [DATA_W-1:0] fetch_word_i,
    output logic              bus_valid_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    input  logic              bus_ready_i,
    output logic              done_o,
    output logic              error_o
);

    localparam int STEP = DATA_W / 8;

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] cnt;
        logic              err;
    } seq_t;

    seq_t s_d, s_q;

    logic want, take, empty;
    logic launch, wr_done;
    logic tmr_load, tmr_last, tmr_busy;

    bss_fetch #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .want_i      (want),
        .fetch_ack_i (fetch_ack_i),
        .fetch_req_o (fetch_req_o),
        .fetch_idx_o (fetch_idx_o),
        .take_o      (take),
        .empty_o     (empty)
    );

    bss_idle_timer #(.CNT_W(DATA_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (fetch_word_i),
        .last_o (tmr_last),
        .busy_o (tmr_busy)
    );

    bss_wport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wport (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .addr_i      (s_q.addr),
        .data_i      (fetch_word_i),
        .bus_ready_i (bus_ready_i),
        .bus_valid_o (bus_valid_o),
        .bus_addr_o  (bus_addr_o),
        .bus_data_o  (bus_data_o),
        .wr_done_o   (wr_done)
    );

    always_comb begin
        s_d      = s_q;
        want     = 1'b0;
        launch   = 1'b0;
        tmr_load = 1'b0;
        unique case (s_q.st)
            ST_HDR: begin
                want = 1'b1;
                if (empty) begin
                    s_d.st  = ST_DONE;
                    s_d.err = 1'b1;
                end else if (take) begin
                    s_d.op = op_e'(fetch_word_i[DATA_W-1 -: OP_W]);
                    unique case (s_d.op)
                        OP_END:  s_d.st = ST_DONE;
                        OP_IDLE: s_d.st = ST_ARG;
                        default: s_d.st = ST_ADDR;
                    endcase
                end
            end
            ST_ADDR: begin
                want = 1'b1;
                if (empty) begin
                    s_d.st  = ST_DONE;
                    s_d.err = 1'b1;
                end else if (take) begin
                    s_d.addr = ADDR_W'(fetch_word_i);
                    s_d.st   = ST_ARG;
                end
            end
            ST_ARG: begin
                want = 1'b1;
                if (empty) begin
                    s_d.st  = ST_DONE;
                    s_d.err = 1'b1;
                end else if (take) begin
                    unique case (s_q.op)
                        OP_WR: begin
                            launch = 1'b1;
                            s_d.st = ST_BUS;
                        end
                        OP_LIST: begin
                            s_d.cnt = fetch_word_i;
                            s_d.st  = (fetch_word_i == '0) ? ST_HDR : ST_DATA;
                        end
                        OP_IDLE: begin
                            tmr_load = (fetch_word_i != '0);
                            s_d.st   = (fetch_word_i == '0) ? ST_HDR : ST_IDLE;
                        end
                        default: s_d.st = ST_HDR;
                    endcase
                end
            end
            ST_DATA: begin
                want = 1'b1;
                if (empty) begin
                    s_d.st  = ST_DONE;
                    s_d.err = 1'b1;
                end else if (take) begin
                    launch  = 1'b1;
                    s_d.cnt = s_q.cnt - DATA_W'(1);
                    s_d.st  = ST_BUS;
                end
            end
            ST_BUS: begin
                if (wr_done) begin
                    if (s_q.op == OP_LIST) begin
                        s_d.addr = s_q.addr + ADDR_W'(STEP);
                        s_d.st   = (s_q.cnt == '0) ? ST_HDR : ST_DATA;
                    end else begin
                        s_d.st = ST_HDR;
                    end
                end
            end
            ST_IDLE: begin
                if (tmr_last) begin
                    s_d.st = ST_HDR;
                end
            end
            ST_DONE: begin
                s_d = s_q;
            end
            default: begin
                s_d.st = ST_DONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_HDR;
            s_q.op <= OP_WR;
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o  = (s_q.st == ST_DONE);
    assign error_o = s_q.err;

    // R6
    no_fetch_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req_o && bus_valid_o));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> !fetch_req_o && !bus_valid_o);

    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o && !fetch_req_o && $stable(error_o));

    // R8
    err_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> done_o);

endmodule

// File: tb/boot_script_seq_test.sv
module boot_script_seq_test;

    localparam int DEPTH = 1024;
    localparam int IDX_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fetch_req;
    logic [IDX_W-1:0] fetch_idx;
    logic             fetch_ack = 1'b0;
    logic [31:0]      fetch_word = '0;
    logic             bus_valid;
    logic [31:0]      bus_addr, bus_data;
    logic             bus_ready = 1'b0;
    logic             done, error;

    always #5 clk = ~clk;

    boot_script_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_req_o  (fetch_req),
        .fetch_idx_o  (fetch_idx),
        .fetch_ack_i  (fetch_ack),
        .fetch_word_i (fetch_word),
        .bus_valid_o  (bus_valid),
        .bus_addr_o   (bus_addr),
        .bus_data_o   (bus_data),
        .bus_ready_i  (bus_ready),
        .done_o       (done),
        .error_o      (error)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mem [DEPTH];
    logic [63:0] exp_q [$];
    int idle_at [int];
    int wp, mem_lat, rdy_lat, acks, exp_idx;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- script builders (driver side of the scoreboard) ----
    task automatic emit(input logic [31:0] w);
        if (wp < DEPTH) mem[wp] = w;
        wp++;
    endtask

    task automatic cmd_write(input logic [31:0] a, input logic [31:0] d, input logic [29:0] junk);
        emit({2'b00, junk});
        emit(a);
        emit(d);
        exp_q.push_back({a, d});
    endtask

    task automatic cmd_list(input logic [31:0] a, input int n, input logic [31:0] seed);
        emit({2'b01, 30'h0000_5A5A});
        emit(a);
        emit(32'(n));
        for (int k = 0; k < n; k++) begin
            logic [31:0] d;
            d = seed ^ (32'(k) * 32'h9E37_79B9);
            if (wp < DEPTH) exp_q.push_back({a + 32'(4 * k), d});
            emit(d);
        end
    endtask

    task automatic cmd_idle(input int t);
        emit({2'b10, 30'h0123_4567});
        idle_at[wp] = t;
        emit(32'(t));
    endtask

    task automatic cmd_end();
        emit({2'b11, 30'h0000_1234});
    endtask

    // ---------------- boot memory model and idle gap monitor ------------
    int lat_n, last_idx, gap_t, gap_n;
    bit gap_on;
    always @(negedge clk) begin
        if (!rst_n) begin
            fetch_ack = 1'b0;
            lat_n = 0;
            gap_on = 1'b0;
        end else begin
            if (fetch_ack) begin
                fetch_ack = 1'b0;
                if (idle_at.exists(last_idx)) begin
                    gap_on = 1'b1;
                    gap_t = idle_at[last_idx];
                    gap_n = 0;
                end
            end else if (fetch_req) begin
                if (fetch_idx != IDX_W'(exp_idx))
                    check(1'b0, "R7", "fetch index", fetch_idx, exp_idx);
                if (lat_n >= mem_lat) begin
                    fetch_ack = 1'b1;
                    fetch_word = mem[fetch_idx];
                    last_idx = int'(fetch_idx);
                    lat_n = 0;
                    acks++;
                    exp_idx++;
                end else begin
                    lat_n++;
                end
            end
            if (gap_on) begin
                if (fetch_req && !fetch_ack) begin
                    check(gap_n == gap_t, "R4", "idle gap cycles", gap_n, gap_t);
                    gap_on = 1'b0;
                end else if (!fetch_ack) begin
                    check(!bus_valid, "R4", "bus quiet in idle", bus_valid, 0);
                    gap_n++;
                end
            end
        end
    end

    // ---------------- bus slave and scoreboard monitor ------------------
    int rw;
    logic [63:0] held;
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ready = 1'b0;
            rw = 0;
        end else if (bus_ready) begin
            bus_ready = 1'b0;
        end else if (bus_valid) begin
            if (rw > 0)
                check({bus_addr, bus_data} == held, "R6", "write held", {bus_addr, bus_data}, held);
            held = {bus_addr, bus_data};
            if (rw >= rdy_lat) begin
                bus_ready = 1'b1;
                rw = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2/R3", "unexpected write", {bus_addr, bus_data}, 0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    check({bus_addr, bus_data} == e, "R2/R3", "write addr/data", {bus_addr, bus_data}, e);
                end
            end else begin
                rw++;
            end
        end
    end

    // ---------------- run control ---------------------------------------
    task automatic start_run(input int ml, input int rl);
        @(negedge clk);
        rst_n = 1'b0;
        mem_lat = ml;
        rdy_lat = rl;
        repeat (2) @(negedge clk);
        // R9 reset state, including after a previous done/error run
        check(fetch_idx == '0, "R9", "reset index", fetch_idx, 0);
        check(!done && !error, "R9", "reset flags", {done, error}, 0);
        check(!bus_valid, "R9", "reset bus_valid", bus_valid, 0);
        for (int i = 0; i < DEPTH; i++) mem[i] = 32'h0;
        exp_q.delete();
        idle_at.delete();
        wp = 0;
        acks = 0;
        exp_idx = 0;
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run(input bit exp_err, input int exp_acks, input string tag);
        int w;
        w = 0;
        while (!done && w < 60000) begin
            @(negedge clk);
            w++;
        end
        check(done, tag, "done raised", done, 1);
        check(error == exp_err, tag, "error flag", error, exp_err);
        check(acks == exp_acks, "R7", "words fetched", acks, exp_acks);
        check(exp_q.size() == 0, "R2/R3", "writes left unseen", exp_q.size(), 0);
        repeat (10) @(negedge clk);
        check(!fetch_req && acks == exp_acks && done, tag, "no fetch after stop", acks, exp_acks);
    endtask

    task automatic run_all();
        // T1: every command, junk in header low bits (R1), zero-length list and idle
        start_run(0, 0);
        cmd_write(32'h1000_0010, 32'hCAFE_0001, 30'h2ABC_1234);
        cmd_idle(7);
        cmd_list(32'h2000_0000, 3, 32'h1111_0000);
        cmd_list(32'h3000_0000, 0, 32'h0);
        cmd_idle(0);
        cmd_write(32'h1BF0_0030, 32'h8000_00E3, 30'h3FFF_FFFF);
        cmd_end();
        mem[wp]     = 32'h0000_0000;  // a write that must never run (R5)
        mem[wp + 1] = 32'hDEAD_0000;
        mem[wp + 2] = 32'hDEAD_BEEF;
        exp_q.push_back(64'h0);
        exp_q.pop_back();
        release_reset();
        finish_run(1'b0, wp, "R1/R5");

        // T2: 627-word block copy with slow memory and slow slave (R3, R6)
        start_run(2, 3);
        cmd_idle(3);
        cmd_list(32'h4000_0000, 627, 32'hB007_C0DE);
        cmd_write(32'h1BE6_0000, 32'h0000_0008, 30'h0);
        cmd_idle(1);
        cmd_end();
        release_reset();
        finish_run(1'b0, wp, "R5");

        // T3: image of idles only, no end header (R8)
        start_run(1, 0);
        for (int i = 0; i < DEPTH; i += 2) begin
            mem[i] = 32'h8000_0000;
            mem[i + 1] = 32'h0;
        end
        release_reset();
        finish_run(1'b1, DEPTH, "R8");

        // T4: block write whose count runs past the image (R8, R3)
        start_run(0, 1);
        cmd_list(32'h4000_0000, 2000, 32'h0F0F_0F0F);
        release_reset();
        finish_run(1'b1, DEPTH, "R8");

        // T5: back to back single writes with memory latency (R2)
        start_run(3, 0);
        cmd_write(32'h0000_0004, 32'h0000_0001, 30'h1);
        cmd_write(32'hFFFF_FFFC, 32'hFFFF_FFFF, 30'h2);
        cmd_end();
        release_reset();
        finish_run(1'b0, wp, "R2");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                check(1'b0, "watchdog", "run did not finish", 0, 1);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule